// File: doc/BRIEF.md
# Display Memory Command Stream Decoder

This block sits behind a serial slave interface that has already framed, received and acknowledged bytes. It takes that byte stream and works out which bytes are addresses and which are data. Data bytes are written into a display/control memory that is organised as rows and columns. Each row holds character registers, and an extra row holds control registers.

A transfer opens with a row address. A row address is a byte with its top bit set. Next comes a column address, which is a byte with its top bit clear. Bit 6 of the column byte picks one of three packet formats:

- **Fully addressed:** row, column, data is repeated for every datum.
- **Same-row:** column and data pairs follow one row address.
- **Streaming:** row and column are sent once. Every byte after that is data, and the address steps forward after each write.

A stop marker ends a transfer and a start marker begins one. Each marker puts the parser back to waiting for a row address. Writes that land outside the implemented array are dropped and pulse an error flag. Bytes that break the packet rules are dropped and pulse the same flag.

The parser has five states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a row address |
| `ST_WANT_COL` | A row is held, waiting for a column |
| `ST_WANT_INFO` | Waiting for the data byte of a fully addressed or same-row packet |
| `ST_WANT_ADDR` | A data byte was just written; the next byte must be a row or a column |
| `ST_STREAM` | Every byte is data |

Transitions:

| From | Byte or event | To |
|---|---|---|
| `ST_IDLE` | Row byte | `ST_WANT_COL` |
| `ST_IDLE` | Column byte | Stays; error |
| `ST_WANT_COL` | Row byte | Stays; row replaced |
| `ST_WANT_COL` | Column byte, bit 6 = 0 | `ST_WANT_INFO` |
| `ST_WANT_COL` | Column byte, bit 6 = 1 | `ST_STREAM` |
| `ST_WANT_INFO` | Any byte | `ST_WANT_ADDR` |
| `ST_WANT_ADDR` | Row byte | `ST_WANT_COL` |
| `ST_WANT_ADDR` | Column byte, bit 6 = 0 | `ST_WANT_INFO` |
| `ST_WANT_ADDR` | Column byte, bit 6 = 1 | Stays; error |
| `ST_STREAM` | Any byte | Stays |
| Any state | Start or stop marker | `ST_IDLE` |

Top module: `dram_cmd_decoder`

## Requirements
- R1: After reset `wr_en` and `proto_err` are 0, and the parser waits for a row address.
- R2: When an address is expected, a byte with bit 7 = 1 is a row address. Its low 4 bits give the row and bits 6:4 are ignored. A byte with bit 7 = 0 is a column address. Bits 4:0 give the column, bit 5 is ignored, and bit 6 selects streaming (1) or not (0). Address bytes cause no write and no error.
- R3: Fully addressed packet: the sequence row, column (bit 6 = 0), data writes the data at (row, column). `wr_en` is high for exactly the one cycle after the clock edge that takes the data byte. `wr_row`, `wr_col` and `wr_data` are valid in that same cycle.
- R4: Same-row packet: after a data byte, a column byte with bit 7 = 0 and bit 6 = 0 sets a new column in the same row. The byte that follows is written there.
- R5: Streaming: a column byte with bit 6 = 1 directly after a row byte makes every later byte data. The first data byte goes to the start address. The column then steps by one after each data byte. After column 23 (`NUM_COLS-1`) the column wraps to 0 and the row increments.
- R6: In streaming, bytes with bit 7 = 1 are written as data. They are not taken as row addresses.
- R7: After a data byte, a row byte starts a new fully addressed packet. A column byte with bit 6 = 1 that arrives right after a data byte is refused: it pulses `proto_err` for one cycle, writes nothing, and the parser still waits for an address.
- R8: A data byte aimed at row ≥ 11 (`NUM_ROWS`) or column ≥ 24 (`NUM_COLS`) is dropped. It pulses `proto_err` for one cycle and `wr_en` stays 0. `wr_en` and `proto_err` are never high together.
- R9: A column byte that arrives while a row address is expected pulses `proto_err` and writes nothing.
- R10: A start or stop marker returns the parser to waiting for a row address. This ends streaming. A byte presented in the same cycle as a marker is ignored and gives no write and no error.
- R11: A row byte that arrives while a column is expected replaces the held row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte |
| frame_start | input | 1 | Start condition seen on the serial bus |
| frame_stop | input | 1 | Stop condition seen on the serial bus |
| wr_en | output | 1 | Memory write enable, one cycle per accepted data byte |
| wr_row | output | ROW_W | Memory row address |
| wr_col | output | COL_W | Memory column address |
| wr_data | output | 8 | Memory write data |
| proto_err | output | 1 | One-cycle pulse for a dropped byte |

## Verification
Every row value from 0 to 15 is crossed with every column value from 0 to 31 in fully addressed packets. A wrong range bound would write a control row that does not exist, or would refuse a legal edge cell such as (10, 23). The don't-care bits are toggled across the sweep, so a decoder that reads them into the address would miscompare.

A streaming run of 300 bytes crosses every row boundary and runs off the end of the array. An off-by-one in the column wrap would shift every later row. Treating data bytes with the top bit set as row addresses would break the stream at once.

Short directed sequences cover the remaining corners:
- a switch to streaming straight after a data byte, which must be refused;
- a return from the same-row format to the fully addressed format;
- a row byte that replaces a held row;
- a stop marker that arrives mid-stream;
- a byte in the same cycle as a marker.

A design that kept streaming after a stop, or took a byte alongside a marker, would produce an unexpected write.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WANT_COL,
        ST_WANT_INFO,
        ST_WANT_ADDR,
        ST_STREAM
    } dcd_state_e;

endpackage

// File: rtl/dcd_classify.sv
module dcd_classify #(
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input  logic [7:0]       byte_data,
    output logic             is_row,
    output logic             is_stream,
    output logic [ROW_W-1:0] row_idx,
    output logic [COL_W-1:0] col_idx
);

    // Bit 7 separates row addresses from column addresses;
    // bit 6 of a column address requests the streaming format.
    always_comb begin
        is_row    = byte_data[7];
        is_stream = byte_data[6];
        row_idx   = byte_data[ROW_W-1:0];
        col_idx   = byte_data[COL_W-1:0];
    end

endmodule

// File: rtl/dcd_addr.sv
module dcd_addr #(
    parameter int NUM_ROWS = 11,
    parameter int NUM_COLS = 24,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_row,
    input  logic [ROW_W-1:0] row_in,
    input  logic             load_col,
    input  logic [COL_W-1:0] col_in,
    input  logic             advance,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col,
    output logic             in_range
);

    localparam logic [ROW_W:0]   ROW_LIM  = (ROW_W+1)'(NUM_ROWS);
    localparam logic [COL_W:0]   COL_LIM  = (COL_W+1)'(NUM_COLS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row <= '0;
            cur_col <= '0;
        end else begin
            if (load_row) begin
                cur_row <= row_in;
            end
            if (load_col) begin
                cur_col <= col_in;
            end else if (advance) begin
                // A column at or past the last one wraps to 0 and moves on one row.
                if (cur_col >= LAST_COL) begin
                    cur_col <= '0;
                    cur_row <= cur_row + 1'b1;
                end else begin
                    cur_col <= cur_col + 1'b1;
                end
            end
        end
    end

    always_comb begin
        in_range = ({1'b0, cur_row} < ROW_LIM) && ({1'b0, cur_col} < COL_LIM);
    end

endmodule

// File: rtl/dcd_fsm.sv
module dcd_fsm
    import dcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic frame_mark,
    input  logic is_row,
    input  logic is_stream,
    output logic load_row,
    output logic load_col,
    output logic do_write,
    output logic advance,
    output logic seq_err
);

    dcd_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt      = state;
        load_row = 1'b0;
        load_col = 1'b0;
        do_write = 1'b0;
        advance  = 1'b0;
        seq_err  = 1'b0;
        if (frame_mark) begin
            // Start or stop: any byte in this same cycle is ignored.
            nxt = ST_IDLE;
        end else if (byte_vld) begin
            unique case (state)
                ST_IDLE: begin
                    if (is_row) begin
                        load_row = 1'b1;
                        nxt      = ST_WANT_COL;
                    end else begin
                        seq_err = 1'b1;
                    end
                end
                ST_WANT_COL: begin
                    if (is_row) begin
                        load_row = 1'b1;
                    end else begin
                        load_col = 1'b1;
                        nxt      = is_stream ? ST_STREAM : ST_WANT_INFO;
                    end
                end
                ST_WANT_INFO: begin
                    do_write = 1'b1;
                    nxt      = ST_WANT_ADDR;
                end
                ST_WANT_ADDR: begin
                    if (is_row) begin
                        load_row = 1'b1;
                        nxt      = ST_WANT_COL;
                    end else if (is_stream) begin
                        // Streaming may only begin straight after a row address.
                        seq_err = 1'b1;
                    end else begin
                        load_col = 1'b1;
                        nxt      = ST_WANT_INFO;
                    end
                end
                ST_STREAM: begin
                    do_write = 1'b1;
                    advance  = 1'b1;
                end
                default: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder #(
    parameter int NUM_ROWS = 11,
    parameter int NUM_COLS = 24,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             frame_start,
    input  logic             frame_stop,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data,
    output logic             proto_err
);

    logic             is_row, is_stream;
    logic [ROW_W-1:0] row_idx, cur_row;
    logic [COL_W-1:0] col_idx, cur_col;
    logic             load_row, load_col, do_write, advance, seq_err, in_range;
    logic             frame_mark;

    assign frame_mark = frame_start | frame_stop;

    dcd_classify #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
        .byte_data (byte_data),
        .is_row    (is_row),
        .is_stream (is_stream),
        .row_idx   (row_idx),
        .col_idx   (col_idx)
    );

    dcd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .frame_mark (frame_mark),
        .is_row     (is_row),
        .is_stream  (is_stream),
        .load_row   (load_row),
        .load_col   (load_col),
        .do_write   (do_write),
        .advance    (advance),
        .seq_err    (seq_err)
    );

    dcd_addr #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS),
        .ROW_W    (ROW_W),
        .COL_W    (COL_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_row (load_row),
        .row_in   (row_idx),
        .load_col (load_col),
        .col_in   (col_idx),
        .advance  (advance),
        .cur_row  (cur_row),
        .cur_col  (cur_col),
        .in_range (in_range)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            proto_err <= 1'b0;
            wr_row    <= '0;
            wr_col    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en     <= do_write & in_range;
            proto_err <= seq_err | (do_write & ~in_range);
            if (do_write) begin
                wr_row  <= cur_row;
                wr_col  <= cur_col;
                wr_data <= byte_data;
            end
        end
    end

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
    parameter int NUM_ROWS = 11,
    parameter int NUM_COLS = 24,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic             frame_start,
    input logic             frame_stop,
    input logic             wr_en,
    input logic [ROW_W-1:0] wr_row,
    input logic [COL_W-1:0] wr_col,
    input logic             proto_err
);

    AST_WR_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && proto_err)); // R8

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_row) < NUM_ROWS) && (int'(wr_col) < NUM_COLS)); // R8

    AST_OUT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_vld) |-> !wr_en && !proto_err); // R3

    AST_MARKER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start || frame_stop) |-> !wr_en && !proto_err); // R10

endmodule

bind dram_cmd_decoder dcd_checker #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .frame_start (frame_start),
    .frame_stop  (frame_stop),
    .wr_en       (wr_en),
    .wr_row      (wr_row),
    .wr_col      (wr_col),
    .proto_err   (proto_err)
);

// File: tb/dram_cmd_decoder_test.sv
`timescale 1ns/1ps
module dram_cmd_decoder_test;

    localparam int NR = 11;
    localparam int NC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       frame_start = 1'b0;
    logic       frame_stop = 1'b0;
    logic       wr_en, proto_err;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dram_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_start(frame_start), .frame_stop(frame_stop),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .proto_err(proto_err)
    );

    task automatic check(input bit ewe, input bit eerr, input int er, input int ec,
                         input int ed, input string tag);
        bit bad;
        vectors++;
        bad = (wr_en !== ewe) || (proto_err !== eerr);
        if (ewe && !bad)
            bad = (int'(wr_row) != er) || (int'(wr_col) != ec) || (int'(wr_data) != ed);
        if (bad) begin
            fails++;
            $display("FAIL %s: got we=%0b err=%0b r=%0d c=%0d d=%02h exp we=%0b err=%0b r=%0d c=%0d d=%02h",
                     tag, wr_en, proto_err, wr_row, wr_col, wr_data, ewe, eerr, er, ec, ed);
        end
    endtask

    // Present one byte for one cycle, then sample the registered result.
    task automatic send(input logic [7:0] b, input bit ewe, input bit eerr,
                        input int er, input int ec, input string tag);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
        check(ewe, eerr, er, ec, int'(b), tag);
    endtask

    task automatic marker(input bit is_stop, input bit with_byte, input logic [7:0] b);
        @(negedge clk);
        frame_start = !is_stop;
        frame_stop  = is_stop;
        byte_vld    = with_byte;
        byte_data   = b;
        @(negedge clk);
        frame_start = 1'b0;
        frame_stop  = 1'b0;
        byte_vld    = 1'b0;
        check(1'b0, 1'b0, 0, 0, 0, "R10 marker cycle");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 1'b0, 0, 0, 0, "R1 reset state");
        send(8'h12, 1'b0, 1'b1, 0, 0, "R1 R9 column byte before row");

        // R2 R3 R8: full sweep of the row and column fields in fully addressed packets
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 32; c++) begin
                logic [7:0] rb, cb, db;
                bit ok;
                rb = 8'h80 | 8'(r) | 8'((c & 7) << 4);
                cb = 8'(c) | 8'((r & 1) << 5);
                db = 8'((r * 32 + c) ^ 8'h5A);
                ok = (r < NR) && (c < NC);
                send(rb, 1'b0, 1'b0, 0, 0, "R2 row byte");
                send(cb, 1'b0, 1'b0, 0, 0, "R2 column byte");
                send(db, ok, !ok, r, c, ok ? "R3 addressed write" : "R8 out of range");
            end
        end

        // R11 row replaced while column expected
        marker(1'b0, 1'b0, 8'h00);
        send(8'h81, 1'b0, 1'b0, 0, 0, "R11 first row");
        send(8'h85, 1'b0, 1'b0, 0, 0, "R11 second row");
        send(8'h00, 1'b0, 1'b0, 0, 0, "R11 column");
        send(8'h3C, 1'b1, 1'b0, 5, 0, "R11 write uses replaced row");

        // R4 R7 format switching
        send(8'h82, 1'b0, 1'b0, 0, 0, "R7 row");
        send(8'h05, 1'b0, 1'b0, 0, 0, "R7 column");
        send(8'hAA, 1'b1, 1'b0, 2, 5, "R3 write");
        send(8'h07, 1'b0, 1'b0, 0, 0, "R4 same-row column");
        send(8'hBB, 1'b1, 1'b0, 2, 7, "R4 same-row write");
        send(8'h83, 1'b0, 1'b0, 0, 0, "R7 back to addressed row");
        send(8'h01, 1'b0, 1'b0, 0, 0, "R7 column");
        send(8'hCC, 1'b1, 1'b0, 3, 1, "R7 addressed write");
        send(8'h45, 1'b0, 1'b1, 0, 0, "R7 stream column after data refused");
        send(8'h06, 1'b0, 1'b0, 0, 0, "R7 still expects address");
        send(8'hDD, 1'b1, 1'b0, 3, 6, "R7 write after refusal");

        // R5 R6 R10 short stream, stop mid-stream
        send(8'h84, 1'b0, 1'b0, 0, 0, "R5 row");
        send(8'h42, 1'b0, 1'b0, 0, 0, "R5 stream column");
        send(8'h91, 1'b1, 1'b0, 4, 2, "R6 top-bit byte is data");
        send(8'h05, 1'b1, 1'b0, 4, 3, "R5 stream advance");
        marker(1'b1, 1'b1, 8'h77);
        send(8'h05, 1'b0, 1'b1, 0, 0, "R10 stream ended by stop");
        marker(1'b0, 1'b1, 8'h86);
        send(8'h05, 1'b0, 1'b1, 0, 0, "R10 byte with start ignored");

        // R5 long stream across all rows and past the array end
        send(8'h80, 1'b0, 1'b0, 0, 0, "R5 row");
        send(8'h40, 1'b0, 1'b0, 0, 0, "R5 stream column");
        for (int i = 0; i < 300; i++) begin
            int r, c;
            bit ok;
            r = i / NC;
            c = i % NC;
            ok = r < NR;
            send(8'((i * 7 + 3) & 8'hFF), ok, !ok, r, c, ok ? "R5 stream write" : "R8 stream past end");
        end
        marker(1'b1, 1'b0, 8'h00);

        summary();
    end

endmodule